// File: doc/BRIEF.md
# UART Channel FIFO and Interrupt-Level Controller

This block holds the transmit and receive byte queues of one 16550-style serial channel and derives the level-type interrupt lines, the transmitter status bits and the two ready lines from their fill. The host side writes transmit bytes, reads received bytes, writes the FIFO control byte and acknowledges the line status. The serial side pops transmit bytes and pushes bytes delivered by a deserializer. Baud timing, shifting, modem lines and scratch storage are outside it.

With queueing off, each direction is a one-byte holding register. With queueing on, each direction is a 16-entry first-in first-out queue and both interrupt lines come from fill comparisons: the receive line against a selectable trigger, the transmit line against a fixed free-space threshold. A separate block-transfer bit leaves the interrupt lines untouched and only changes the ready lines. In character mode they follow "anything present" or "any room". In block mode they assert at the threshold and release only when the queue drains or fills completely.

Top module: `uart_fifo_irq_ctrl`

## Requirements
- R1: After reset both queues are empty, queueing and block mode are off and the receive trigger code is 0; int_tx=1, int_rx=0, tx_ready=1, rx_ready=0, lsr_thre=1, lsr_temt=1 (with tx_shift_busy=0) and lsr_overrun=0.
- R2: With fcr_data bit 0 stored as 0, each direction holds at most one byte: a host write or a received byte that finds the holder full is dropped. int_tx is 1 exactly when the transmit holder is empty, and int_rx is 1 exactly when the receive holder has a byte.
- R3: With bit 0 stored as 1, each queue holds 16 bytes and returns them in arrival order on tx_byte / rbr_data, where the head is visible before the pop. A push into a full queue is dropped.
- R4: With queueing on, int_tx is 1 exactly when the transmit queue has at least 8 free entries, so its fill is 8 or less.
- R5: With queueing on, int_rx is 1 exactly when the receive fill is at least the trigger selected by fcr_data bits 7:6: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14.
- R6: In character mode (bit 3 stored as 0, or queueing off), rx_ready is 1 when the receive side holds at least one byte, and tx_ready is 1 when the transmit side has at least one free entry.
- R7: In block mode (bits 0 and 3 stored as 1), rx_ready rises when the fill reaches the receive trigger and stays up until the queue is empty. tx_ready rises when at least 8 entries are free and stays up until no entry is free.
- R8: The block-mode bit has no effect on int_tx or int_rx.
- R9: An FCR write with bit 1 set empties the receive queue, and one with bit 2 set empties the transmit queue, in the same cycle. Neither bit is stored, so a later write without it leaves the queues alone.
- R10: An FCR write whose bit 0 differs from the stored value empties both queues.
- R11: A received byte that finds the receive side full sets lsr_overrun. The flag holds until an lsr_rd pulse clears it, and a new overrun in the same cycle as lsr_rd wins.
- R12: lsr_thre is 1 when the transmit side has a free entry. lsr_temt is 1 when the transmit side is empty and tx_shift_busy is 0.
- R13: A read or pop of an empty side changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| thr_wr | input | 1 | Host write strobe for the transmit side |
| thr_data | input | 8 | Byte written by the host |
| rbr_rd | input | 1 | Host read strobe, pops the receive head |
| rbr_data | output | 8 | Receive head byte |
| fcr_wr | input | 1 | FIFO control write strobe |
| fcr_data | input | 8 | FIFO control byte (bit 0 queue on, 1 clear rx, 2 clear tx, 3 block mode, 7:6 trigger) |
| lsr_rd | input | 1 | Line status acknowledge, clears the overrun flag |
| rx_strobe | input | 1 | Deserializer delivers a byte |
| rx_data | input | 8 | Byte from the deserializer |
| tx_pop | input | 1 | Serializer takes the transmit head |
| tx_shift_busy | input | 1 | Serializer shift register still holds bits |
| tx_byte | output | 8 | Transmit head byte |
| tx_avail | output | 1 | Transmit side holds at least one byte |
| int_tx | output | 1 | Transmit interrupt level |
| int_rx | output | 1 | Receive interrupt level |
| lsr_overrun | output | 1 | Receive overrun flag |
| lsr_thre | output | 1 | Transmit side has room |
| lsr_temt | output | 1 | Transmitter fully empty |
| tx_ready | output | 1 | Transmit ready line |
| rx_ready | output | 1 | Receive ready line |

## Verification
The hardest situation to reach is the hysteresis of the block-mode ready lines. The queue has to be driven past a threshold and then walked back the other way, so that each value of the fill is seen once while the line is held and once while it is released. The bench fills the transmit queue to 16 and pops it back to empty, checking tx_ready at every step. It does the same on the receive side with trigger 4. Trigger changes while data sits in the receive queue are covered by the vector table, which rewrites the control byte over a non-empty queue.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  // Stored part of the FIFO control byte.
  typedef struct packed {
    logic [1:0] trig_sel;
    logic       dma;
    logic       fifo_en;
  } fcr_state_t;

  localparam fcr_state_t FCR_RESET = '{trig_sel: 2'b00, dma: 1'b0, fifo_en: 1'b0};

endpackage

// File: rtl/ufi_rst_sync.sv
module ufi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end

endmodule

// File: rtl/ufi_fifo.sv
module ufi_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         cap_one,
  input  logic                         push,
  input  logic [DW-1:0]                push_data,
  input  logic                         pop,
  output logic [DW-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CAP_FULL = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] cap;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + AW'(1);
  endfunction

  assign cap     = cap_one ? CW'(1) : CAP_FULL;
  assign full    = (cnt_q >= cap);
  assign empty   = (cnt_q == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign head    = mem[rd_q];
  assign count   = cnt_q;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wr_d = ptr_inc(wr_q);
      if (pop_ok)  rd_d = ptr_inc(rd_q);
      cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage array: no reset, written only on an accepted push.
  always_ff @(posedge clk) begin
    if (push_ok && !clr) begin
      mem[wr_q] <= push_data;
    end
  end

  // R3: the fill never passes the queue depth.
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CAP_FULL);

  // R3: without a clear the fill moves by at most one entry per cycle.
  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CW'(1))
             || (cnt_q == $past(cnt_q) - CW'(1)));

  // R13: popping an empty queue leaves it empty.
  a_r13_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !clr) |=> empty);

endmodule

// File: rtl/ufi_ready.sv
module ufi_ready (
  input  logic clk,
  input  logic rst_n,
  input  logic block_mode,
  input  logic level_ok,
  input  logic set_cond,
  input  logic drain_cond,
  output logic ready
);

  logic hold_q, hold_d;

  // Block mode: assert at the threshold, hold until the drain condition.
  always_comb begin
    if (block_mode) begin
      ready = set_cond | (hold_q & ~drain_cond);
    end else begin
      ready = level_ok;
    end
    hold_d = ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  // R7: in block mode a raised line stays up until the drain condition.
  a_r7_hold_until_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (block_mode && $past(block_mode) && $past(ready) && !drain_cond) |-> ready);

  // R7: in block mode the line rises only at the threshold.
  a_r7_rise_at_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    (block_mode && $past(block_mode) && !$past(ready) && ready) |-> set_cond);

endmodule

// File: rtl/uart_fifo_irq_ctrl.sv
module uart_fifo_irq_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int DW           = 8,
  parameter int DEPTH        = 16,
  parameter int TX_FREE_TRIG = 8,
  parameter int RX_TRIG_0    = 1,
  parameter int RX_TRIG_1    = 4,
  parameter int RX_TRIG_2    = 8,
  parameter int RX_TRIG_3    = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          thr_wr,
  input  logic [DW-1:0] thr_data,
  input  logic          rbr_rd,
  output logic [DW-1:0] rbr_data,
  input  logic          fcr_wr,
  input  logic [7:0]    fcr_data,
  input  logic          lsr_rd,
  input  logic          rx_strobe,
  input  logic [DW-1:0] rx_data,
  input  logic          tx_pop,
  input  logic          tx_shift_busy,
  output logic [DW-1:0] tx_byte,
  output logic          tx_avail,
  output logic          int_tx,
  output logic          int_rx,
  output logic          lsr_overrun,
  output logic          lsr_thre,
  output logic          lsr_temt,
  output logic          tx_ready,
  output logic          rx_ready
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] TXT      = CW'(TX_FREE_TRIG);
  localparam logic [CW-1:0] CAP_FULL = CW'(DEPTH);

  logic       rst_s_n;
  fcr_state_t fcr_q, fcr_d;
  logic       rx_clr, tx_clr, mode_flip;
  logic       ovr_q, ovr_d;
  logic [CW-1:0] rx_cnt, tx_cnt, tx_cap, tx_free, rx_trig;
  logic       rx_full, rx_empty, tx_full, tx_empty;
  logic       block_mode;
  logic       unused_fcr_bits;

  assign unused_fcr_bits = ^fcr_data[5:4];

  ufi_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  // Control byte decode and storage.
  assign mode_flip = fcr_wr & (fcr_data[0] != fcr_q.fifo_en);
  assign rx_clr    = (fcr_wr & fcr_data[1]) | mode_flip;
  assign tx_clr    = (fcr_wr & fcr_data[2]) | mode_flip;

  always_comb begin
    fcr_d = fcr_q;
    if (fcr_wr) begin
      fcr_d.fifo_en  = fcr_data[0];
      fcr_d.dma      = fcr_data[3];
      fcr_d.trig_sel = fcr_data[7:6];
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) fcr_q <= FCR_RESET;
    else          fcr_q <= fcr_d;
  end

  // Queues.
  ufi_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .clr       (rx_clr),
    .cap_one   (~fcr_q.fifo_en),
    .push      (rx_strobe),
    .push_data (rx_data),
    .pop       (rbr_rd),
    .head      (rbr_data),
    .count     (rx_cnt),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  ufi_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .clr       (tx_clr),
    .cap_one   (~fcr_q.fifo_en),
    .push      (thr_wr),
    .push_data (thr_data),
    .pop       (tx_pop),
    .head      (tx_byte),
    .count     (tx_cnt),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  // Overrun flag: a new overrun wins over the acknowledge.
  always_comb begin
    ovr_d = ovr_q;
    if (lsr_rd) ovr_d = 1'b0;
    if (rx_strobe && rx_full && !rx_clr) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) ovr_q <= 1'b0;
    else          ovr_q <= ovr_d;
  end

  // Levels and comparisons.
  always_comb begin
    case (fcr_q.trig_sel)
      2'b00:   rx_trig = CW'(RX_TRIG_0);
      2'b01:   rx_trig = CW'(RX_TRIG_1);
      2'b10:   rx_trig = CW'(RX_TRIG_2);
      default: rx_trig = CW'(RX_TRIG_3);
    endcase
  end

  assign tx_cap     = fcr_q.fifo_en ? CAP_FULL : CW'(1);
  assign tx_free    = tx_cap - tx_cnt;
  assign block_mode = fcr_q.fifo_en & fcr_q.dma;

  assign int_tx = fcr_q.fifo_en ? (tx_free >= TXT) : tx_empty;
  assign int_rx = fcr_q.fifo_en ? (rx_cnt >= rx_trig) : ~rx_empty;

  assign tx_avail    = ~tx_empty;
  assign lsr_overrun = ovr_q;
  assign lsr_thre    = ~tx_full;
  assign lsr_temt    = tx_empty & ~tx_shift_busy;

  ufi_ready u_rx_ready (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .block_mode (block_mode),
    .level_ok   (~rx_empty),
    .set_cond   (rx_cnt >= rx_trig),
    .drain_cond (rx_empty),
    .ready      (rx_ready)
  );

  ufi_ready u_tx_ready (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .block_mode (block_mode),
    .level_ok   (~tx_full),
    .set_cond   (tx_free >= TXT),
    .drain_cond (tx_free == '0),
    .ready      (tx_ready)
  );

  // R2: with queueing off neither side ever holds more than one byte.
  a_r2_single_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    !fcr_q.fifo_en |-> (rx_cnt <= CW'(1)) && (tx_cnt <= CW'(1)));

  // R9: a receive clear request leaves the receive side empty.
  a_r9_rx_clear: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fcr_wr && fcr_data[1]) |=> rx_empty);

  // R9: a transmit clear request leaves the transmit side empty.
  a_r9_tx_clear: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fcr_wr && fcr_data[2]) |=> tx_empty);

  // R10: toggling the queue enable empties both sides.
  a_r10_mode_flip: assert property (@(posedge clk) disable iff (!rst_s_n)
    mode_flip |=> (rx_empty && tx_empty));

  // R11: a byte arriving at a full receive side raises the overrun flag.
  a_r11_overrun_set: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rx_strobe && rx_full && !rx_clr) |=> lsr_overrun);

  // R11: without an acknowledge the overrun flag never falls.
  a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_s_n)
    (lsr_overrun && !lsr_rd) |=> lsr_overrun);

endmodule

// File: tb/uart_fifo_irq_ctrl_tb_top.sv
module uart_fifo_irq_ctrl_tb_top;

  localparam int OP_FCR = 0;
  localparam int OP_THR = 1;
  localparam int OP_RX  = 2;
  localparam int OP_RD  = 3;
  localparam int OP_POP = 4;
  localparam int OP_ACK = 5;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] arg;
    logic [5:0] exp;   // {int_tx, int_rx, tx_ready, rx_ready, lsr_thre, lsr_temt}
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{3'd1, 8'h11, 6'b000000},  // R2 one byte in transmit holder
    '{3'd1, 8'h22, 6'b000000},  // R2 second write dropped
    '{3'd4, 8'h00, 6'b101011},  // R2 holder drained
    '{3'd2, 8'h33, 6'b111111},  // R2 receive holder full
    '{3'd3, 8'h00, 6'b101011},  // R2 receive holder read
    '{3'd0, 8'h01, 6'b101011},  // R10 queueing on
    '{3'd1, 8'h44, 6'b101010},  // R4 R12 fill 1
    '{3'd0, 8'hC9, 6'b101010},  // R7 block mode, trigger 14
    '{3'd2, 8'h55, 6'b101010},  // R5 fill 1 under trigger 14
    '{3'd0, 8'h09, 6'b111110},  // R5 R7 trigger 1 reached
    '{3'd0, 8'h49, 6'b101110},  // R7 trigger 4, line held
    '{3'd0, 8'h41, 6'b101110},  // R6 character mode
    '{3'd0, 8'h47, 6'b101011},  // R9 clear both
    '{3'd0, 8'h00, 6'b101011}   // R10 queueing off
  };

  logic       clk;
  logic       rst_n;
  logic       thr_wr, rbr_rd, fcr_wr, lsr_rd, rx_strobe, tx_pop, tx_shift_busy;
  logic [7:0] thr_data, fcr_data, rx_data, rbr_data, tx_byte;
  logic       tx_avail, int_tx, int_rx, lsr_overrun, lsr_thre, lsr_temt, tx_ready, rx_ready;

  int checks;
  int errors;

  uart_fifo_irq_ctrl dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .thr_wr        (thr_wr),
    .thr_data      (thr_data),
    .rbr_rd        (rbr_rd),
    .rbr_data      (rbr_data),
    .fcr_wr        (fcr_wr),
    .fcr_data      (fcr_data),
    .lsr_rd        (lsr_rd),
    .rx_strobe     (rx_strobe),
    .rx_data       (rx_data),
    .tx_pop        (tx_pop),
    .tx_shift_busy (tx_shift_busy),
    .tx_byte       (tx_byte),
    .tx_avail      (tx_avail),
    .int_tx        (int_tx),
    .int_rx        (int_rx),
    .lsr_overrun   (lsr_overrun),
    .lsr_thre      (lsr_thre),
    .lsr_temt      (lsr_temt),
    .tx_ready      (tx_ready),
    .rx_ready      (rx_ready)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive one operation for one cycle; returns at the next falling edge,
  // after the registers have taken the operation.
  task automatic do_op(input int op, input logic [7:0] arg);
    @(negedge clk);
    case (op)
      OP_FCR: begin fcr_wr = 1'b1; fcr_data = arg; end
      OP_THR: begin thr_wr = 1'b1; thr_data = arg; end
      OP_RX:  begin rx_strobe = 1'b1; rx_data = arg; end
      OP_RD:  rbr_rd = 1'b1;
      OP_POP: tx_pop = 1'b1;
      default: lsr_rd = 1'b1;
    endcase
    @(negedge clk);
    fcr_wr = 1'b0; thr_wr = 1'b0; rx_strobe = 1'b0;
    rbr_rd = 1'b0; tx_pop = 1'b0; lsr_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0;
    thr_wr = 1'b0; rbr_rd = 1'b0; fcr_wr = 1'b0; lsr_rd = 1'b0;
    rx_strobe = 1'b0; tx_pop = 1'b0; tx_shift_busy = 1'b0;
    thr_data = '0; fcr_data = '0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 int_tx", int_tx, 1);
    check("R1 int_rx", int_rx, 0);
    check("R1 tx_ready", tx_ready, 1);
    check("R1 rx_ready", rx_ready, 0);
    check("R1 thre", lsr_thre, 1);
    check("R1 temt", lsr_temt, 1);
    check("R1 overrun", lsr_overrun, 0);
    check("R1 tx_avail", tx_avail, 0);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      do_op(int'(VECS[v].op), VECS[v].arg);
      check($sformatf("R2-table row %0d", v),
            {2'b00, int_tx, int_rx, tx_ready, rx_ready, lsr_thre, lsr_temt},
            {2'b00, VECS[v].exp});
    end

    // R3 R5 R11: receive queue ordering, trigger 8, overrun
    do_op(OP_FCR, 8'h81);
    for (int i = 1; i <= 16; i++) begin
      do_op(OP_RX, 8'h40 + 8'(i));
      check("R5 int_rx trig 8", int_rx, (i >= 8) ? 1 : 0);
    end
    check("R11 no overrun yet", lsr_overrun, 0);
    do_op(OP_RX, 8'hEE);
    check("R11 overrun set", lsr_overrun, 1);
    do_op(OP_FCR, 8'h81);
    check("R11 overrun sticky", lsr_overrun, 1);
    do_op(OP_ACK, 8'h00);
    check("R11 overrun cleared", lsr_overrun, 0);
    for (int i = 1; i <= 16; i++) begin
      check("R3 rx order", rbr_data, 8'h40 + 8'(i));
      do_op(OP_RD, 8'h00);
    end
    check("R3 rx dropped byte absent", rx_ready, 0);
    do_op(OP_RD, 8'h00);
    do_op(OP_RX, 8'h77);
    check("R13 empty read ignored", rbr_data, 8'h77);
    check("R6 rx_ready one byte", rx_ready, 1);
    do_op(OP_RD, 8'h00);

    // R5 trigger codes 01 and 11
    do_op(OP_FCR, 8'h41);
    for (int i = 1; i <= 4; i++) begin
      do_op(OP_RX, 8'(i));
      check("R5 int_rx trig 4", int_rx, (i >= 4) ? 1 : 0);
    end
    for (int i = 5; i <= 13; i++) do_op(OP_RX, 8'(i));
    do_op(OP_FCR, 8'hC1);
    check("R5 trig 14 at fill 13", int_rx, 0);
    do_op(OP_RX, 8'h0E);
    check("R5 trig 14 at fill 14", int_rx, 1);
    do_op(OP_FCR, 8'hC9);
    check("R8 int_rx unchanged by block bit", int_rx, 1);
    do_op(OP_FCR, 8'h03);
    check("R9 rx cleared", int_rx, 0);
    check("R9 rx_ready low", rx_ready, 0);

    // R3 R4 R12: transmit queue
    for (int i = 1; i <= 16; i++) begin
      do_op(OP_THR, 8'h80 + 8'(i));
      check("R4 int_tx", int_tx, (i <= 8) ? 1 : 0);
      check("R12 thre", lsr_thre, (i < 16) ? 1 : 0);
    end
    do_op(OP_THR, 8'hFF);
    check("R12 temt while filled", lsr_temt, 0);
    for (int i = 1; i <= 16; i++) begin
      check("R3 tx order", tx_byte, 8'h80 + 8'(i));
      do_op(OP_POP, 8'h00);
    end
    check("R3 tx drained", tx_avail, 0);
    do_op(OP_POP, 8'h00);
    check("R13 empty pop temt", lsr_temt, 1);
    tx_shift_busy = 1'b1;
    #1;
    check("R12 temt with shifter busy", lsr_temt, 0);
    tx_shift_busy = 1'b0;

    // R7 R8 block mode transmit ready
    do_op(OP_FCR, 8'h09);
    for (int i = 1; i <= 16; i++) begin
      do_op(OP_THR, 8'(i));
      check("R7 tx_ready filling", tx_ready, (i < 16) ? 1 : 0);
    end
    for (int f = 15; f >= 0; f--) begin
      do_op(OP_POP, 8'h00);
      check("R7 tx_ready draining", tx_ready, (f <= 8) ? 1 : 0);
      check("R8 int_tx in block mode", int_tx, (f <= 8) ? 1 : 0);
    end

    // R7 R8 block mode receive ready, trigger 4
    do_op(OP_FCR, 8'h49);
    for (int i = 1; i <= 5; i++) begin
      do_op(OP_RX, 8'(i));
      check("R7 rx_ready filling", rx_ready, (i >= 4) ? 1 : 0);
    end
    for (int f = 4; f >= 0; f--) begin
      do_op(OP_RD, 8'h00);
      check("R7 rx_ready draining", rx_ready, (f > 0) ? 1 : 0);
      check("R8 int_rx in block mode", int_rx, (f >= 4) ? 1 : 0);
    end

    // R9 bits not stored
    do_op(OP_FCR, 8'h01);
    do_op(OP_THR, 8'hA1);
    do_op(OP_RX, 8'hB2);
    do_op(OP_FCR, 8'h03);
    check("R9 tx kept on rx clear", tx_avail, 1);
    check("R9 rx cleared", rx_ready, 0);
    do_op(OP_FCR, 8'h01);
    check("R9 clear bit not stored", tx_avail, 1);
    do_op(OP_FCR, 8'h05);
    check("R9 tx cleared", tx_avail, 0);

    // R10 leaving queue mode empties both sides
    do_op(OP_THR, 8'hC3);
    do_op(OP_RX, 8'hD4);
    do_op(OP_FCR, 8'h00);
    check("R10 tx emptied", tx_avail, 0);
    check("R10 rx emptied", rx_ready, 0);
    check("R10 int_tx", int_tx, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule